// File: doc/BRIEF.md
# Interlaken Metaframe Synchronizer

This block sits on the receive side of a lane, after word alignment. It takes one 67-bit word per valid cycle and finds where each metaframe begins. It tracks the position of each word inside the metaframe and declares lock once the boundary has been confirmed several times. While locked, it watches the scrambler-state control word that follows each sync word. When that word stops arriving, the block gives up the boundary and searches again. Descrambling, CRC checking and word alignment are done elsewhere.

Each word carries a 3-bit header in bits [66:64]. The value 3'b010 marks a framing control word, and its type code sits in bits [63:58]. Any word whose bits [65:64] are 2'b01 is payload. The metaframe length is set on `meta_len` as a word count that includes the sync word. All three outputs are registered, so each one reports on the word presented in the previous cycle.

The controller has three states. In SEARCH it waits for a sync word (SEARCH→VERIFY on a sync word). In VERIFY it counts syncs that land in the predicted slot. A sync at the fourth confirmation moves it to LOCKED (VERIFY→LOCKED), and a missing sync sends it back (VERIFY→SEARCH). In LOCKED it judges the scrambler-state slot, and the third consecutive miss leaves lock (LOCKED→SEARCH).

Top module: `ilk_metaframe_sync`

## Requirements
- R1: `locked` rises in the cycle after the sync word that completes four consecutive metaframes with a sync word in the predicted slot. The first of the four is the candidate found during search.
- R2: A sync word has bits [66:64] = 3'b010 and bits [63:0] = 64'h78F6_78F6_78F6_78F6. The same 64-bit value with header 3'b001 is never taken as a candidate.
- R3: Before lock, a word in the predicted sync slot that is not a sync word drops the candidate. Counting then restarts from zero, so four further consecutive syncs are needed.
- R4: While locked, the word in the slot right after the sync slot must be a control word with header 3'b010 and type bits [63:58] = 6'b001010. If it is not, that counts as a miss. After the third consecutive miss, `locked` falls in the next cycle and the search restarts immediately.
- R5: A matching scrambler-state word clears the miss count, so two misses, one match and two more misses keep lock.
- R6: `mf_start` is high for one cycle after a sync word that arrives in the sync slot while lock is already held. It is low at all other times.
- R7: `payload_valid` is high in the cycle after a valid word received while lock is held, unless that word is a framing control word. Framing control words are those with header 3'b010 and type 6'b011110 (sync), 6'b001010 (scrambler state), 6'b000111 (skip) or 6'b011001 (diagnostic).
- R8: A cycle with `word_valid` low does not advance the slot position. It raises neither `mf_start` nor `payload_valid` in the next cycle.
- R9: During and right after reset, all three outputs are low and the block is in SEARCH.
- R10: The slot position wraps after `meta_len` valid words, with `meta_len` at least 4. This holds for any such length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | `word_data` holds a received word this cycle |
| word_data | input | 67 | Word-aligned received word, header in [66:64] |
| meta_len | input | LEN_W | Metaframe length in words, sync word included |
| locked | output | 1 | Metaframe boundary is locked |
| mf_start | output | 1 | Previous word was the sync word of a locked metaframe |
| payload_valid | output | 1 | Previous word was payload received under lock |

## Verification
A wrong slot position shows up at the ports within one metaframe. The sync word stops producing `mf_start`, and control words begin to leak through as `payload_valid`. A wrong confirmation or miss count shifts the rising or falling edge of `locked` by a whole metaframe. The bench therefore predicts, word by word, the exact cycle of each edge. It does this across several lengths, with inserted idle cycles, fake sync patterns and interleaved scrambler-state misses.

// File: rtl/ilk_msync_pkg.sv
package ilk_msync_pkg;

    localparam int          WORD_W       = 67;
    localparam logic [2:0]  HDR_CONTROL  = 3'b010;
    localparam logic [63:0] SYNC_PATTERN = 64'h78F6_78F6_78F6_78F6;

    localparam logic [5:0]  TYPE_SYNC    = 6'b011110;
    localparam logic [5:0]  TYPE_SCRAM   = 6'b001010;
    localparam logic [5:0]  TYPE_SKIP    = 6'b000111;
    localparam logic [5:0]  TYPE_DIAG    = 6'b011001;
    localparam int          N_FRAME_TYPES = 4;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } msync_state_t;

    typedef struct packed {
        logic is_sync;
        logic is_scram;
        logic is_framing;
    } word_class_t;

endpackage

// File: rtl/ilk_word_class.sv
module ilk_word_class
    import ilk_msync_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_class_t       cls
);

    localparam logic [5:0] FRAME_TYPES [N_FRAME_TYPES] =
        '{TYPE_SYNC, TYPE_SCRAM, TYPE_SKIP, TYPE_DIAG};

    logic                     is_ctrl;
    logic [N_FRAME_TYPES-1:0] type_hit;

    assign is_ctrl = (word[66:64] == HDR_CONTROL);

    for (genvar t = 0; t < N_FRAME_TYPES; t++) begin : g_type
        assign type_hit[t] = (word[63:58] == FRAME_TYPES[t]);
    end

    assign cls.is_sync    = is_ctrl && (word[63:0] == SYNC_PATTERN);
    assign cls.is_scram   = is_ctrl && (word[63:58] == TYPE_SCRAM);
    assign cls.is_framing = is_ctrl && (|type_hit);

endmodule

// File: rtl/ilk_slot_tracker.sv
module ilk_slot_tracker #(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [LEN_W-1:0] meta_len,
    output logic             at_sync_slot,
    output logic             at_scram_slot
);

    logic [LEN_W-1:0] slot_q;
    logic [LEN_W-1:0] last_slot;

    assign last_slot = meta_len - LEN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (load) begin
            slot_q <= LEN_W'(1);
        end else if (advance) begin
            slot_q <= (slot_q == last_slot) ? '0 : slot_q + LEN_W'(1);
        end
    end

    assign at_sync_slot  = (slot_q == '0);
    assign at_scram_slot = (slot_q == LEN_W'(1));

endmodule

// File: rtl/ilk_event_count.sv
module ilk_event_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_W'(LIMIT))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign at_last = (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/ilk_metaframe_sync.sv
module ilk_metaframe_sync
    import ilk_msync_pkg::*;
#(
    parameter int LEN_W      = 14,
    parameter int SYNC_LOCK  = 4,
    parameter int MISS_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic [LEN_W-1:0]  meta_len,
    output logic              locked,
    output logic              mf_start,
    output logic              payload_valid
);

    msync_state_t state_q, state_d;
    word_class_t  cls;

    logic at_sync_slot, at_scram_slot;
    logic slot_load, slot_adv;
    logic sync_clr, sync_inc, sync_last;
    logic miss_clr, miss_inc, miss_last;
    logic mf_start_q, payload_q;

    ilk_word_class u_class (
        .word (word_data),
        .cls  (cls)
    );

    ilk_slot_tracker #(.LEN_W(LEN_W)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (slot_load),
        .advance       (slot_adv),
        .meta_len      (meta_len),
        .at_sync_slot  (at_sync_slot),
        .at_scram_slot (at_scram_slot)
    );

    ilk_event_count #(.LIMIT(SYNC_LOCK)) u_sync_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_clr),
        .inc     (sync_inc),
        .at_last (sync_last)
    );

    ilk_event_count #(.LIMIT(MISS_LIMIT)) u_miss_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (miss_clr),
        .inc     (miss_inc),
        .at_last (miss_last)
    );

    // Next-state and counter control
    always_comb begin
        state_d   = state_q;
        slot_load = 1'b0;
        slot_adv  = 1'b0;
        sync_clr  = 1'b0;
        sync_inc  = 1'b0;
        miss_clr  = 1'b0;
        miss_inc  = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                miss_clr = 1'b1;
                if (word_valid && cls.is_sync) begin
                    state_d   = ST_VERIFY;
                    slot_load = 1'b1;
                    sync_inc  = 1'b1;
                end else begin
                    sync_clr  = 1'b1;
                end
            end
            ST_VERIFY: begin
                miss_clr = 1'b1;
                if (word_valid) begin
                    slot_adv = 1'b1;
                    if (at_sync_slot) begin
                        if (!cls.is_sync) begin
                            state_d  = ST_SEARCH;
                            sync_clr = 1'b1;
                        end else if (sync_last) begin
                            state_d  = ST_LOCKED;
                        end else begin
                            sync_inc = 1'b1;
                        end
                    end
                end
            end
            ST_LOCKED: begin
                sync_clr = 1'b1;
                if (word_valid) begin
                    slot_adv = 1'b1;
                    if (at_scram_slot) begin
                        if (cls.is_scram) begin
                            miss_clr = 1'b1;
                        end else if (miss_last) begin
                            state_d  = ST_SEARCH;
                            miss_clr = 1'b1;
                        end else begin
                            miss_inc = 1'b1;
                        end
                    end
                end
            end
            default: begin
                state_d = ST_SEARCH;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_start_q <= 1'b0;
            payload_q  <= 1'b0;
        end else begin
            mf_start_q <= word_valid && (state_q == ST_LOCKED)
                          && at_sync_slot && cls.is_sync;
            payload_q  <= word_valid && (state_q == ST_LOCKED)
                          && !cls.is_framing;
        end
    end

    assign locked        = (state_q == ST_LOCKED);
    assign mf_start      = mf_start_q;
    assign payload_valid = payload_q;

endmodule

// File: rtl/ilk_metaframe_sync_chk.sv
module ilk_metaframe_sync_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [66:0] word_data,
    input logic        locked,
    input logic        mf_start,
    input logic        payload_valid
);

    logic in_sync;
    logic in_scram;

    assign in_sync  = (word_data[66:64] == 3'b010)
                      && (word_data[63:0] == 64'h78F6_78F6_78F6_78F6);
    assign in_scram = (word_data[66:64] == 3'b010)
                      && (word_data[63:58] == 6'b001010);

    assert_lock_on_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(word_valid && in_sync));

    assert_loss_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(word_valid && !in_scram));

    assert_start_under_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> locked);

    assert_start_not_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mf_start && payload_valid));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> (!mf_start && !payload_valid));

endmodule

bind ilk_metaframe_sync ilk_metaframe_sync_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid    (word_valid),
    .word_data     (word_data),
    .locked        (locked),
    .mf_start      (mf_start),
    .payload_valid (payload_valid)
);

// File: tb/ilk_metaframe_sync_bench.sv
module ilk_metaframe_sync_bench;

    localparam int LEN_W = 14;
    localparam logic [66:0] SYNC_W  = {3'b010, 64'h78F6_78F6_78F6_78F6};
    localparam logic [66:0] FAKE_W  = {3'b001, 64'h78F6_78F6_78F6_78F6};
    localparam logic [66:0] SCRAM_W = {3'b010, 6'b001010, 58'h0123_4567_89AB};
    localparam logic [66:0] SKIP_W  = {3'b010, 6'b000111, 58'h0};
    localparam logic [66:0] DIAG_W  = {3'b010, 6'b011001, 58'h2};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_valid = 1'b0;
    logic [66:0]       word_data = '0;
    logic [LEN_W-1:0]  meta_len = LEN_W'(4);
    logic              locked, mf_start, payload_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic held = 1'b0;

    always #5 clk = ~clk;

    ilk_metaframe_sync #(.LEN_W(LEN_W)) u_ilk_metaframe_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .meta_len      (meta_len),
        .locked        (locked),
        .mf_start      (mf_start),
        .payload_valid (payload_valid)
    );

    task automatic check_out(input logic el, input logic em, input logic ep, input string req);
        n_tests++;
        if (locked !== el || mf_start !== em || payload_valid !== ep) begin
            n_fail++;
            $display("FAIL %s: actual lock=%b start=%b pay=%b expected lock=%b start=%b pay=%b",
                     req, locked, mf_start, payload_valid, el, em, ep);
        end
    endtask

    task automatic xfer(input logic v, input logic [66:0] w, input logic el,
                        input logic em, input logic ep, input string req);
        @(negedge clk);
        word_valid = v;
        word_data  = w;
        @(posedge clk);
        #1;
        check_out(el, em, ep, req);
        held = el;
    endtask

    function automatic logic [66:0] data_word(input int i);
        return {3'b001, 32'hD00D_0000, 32'(i)};
    endfunction

    // One metaframe of L words; expected lock after slot 0 and after the rest.
    task automatic send_frame(input int L, input bit sync_ok, input bit fake,
                              input bit scram_ok, input bit gap,
                              input logic lk_sync, input logic lk_rest, input string req);
        logic [66:0] w;
        logic hb;
        hb = held;
        w  = sync_ok ? SYNC_W : (fake ? FAKE_W : data_word(0));
        xfer(1'b1, w, lk_sync, hb && sync_ok, hb && !sync_ok, req);
        hb = held;
        w  = scram_ok ? SCRAM_W : data_word(1);
        xfer(1'b1, w, lk_rest, 1'b0, hb && !scram_ok, req);
        if (gap) begin
            xfer(1'b0, SYNC_W, lk_rest, 1'b0, 1'b0, "R8 idle word");
            xfer(1'b0, data_word(7), lk_rest, 1'b0, 1'b0, "R8 idle word");
        end
        for (int i = 2; i < L; i++) begin
            hb = held;
            if (i == 2 && L >= 5) begin
                xfer(1'b1, SKIP_W, lk_rest, 1'b0, 1'b0, "R7 skip word");
            end else if (i == 3 && L >= 6) begin
                xfer(1'b1, DIAG_W, lk_rest, 1'b0, 1'b0, "R7 diag word");
            end else begin
                xfer(1'b1, data_word(i), lk_rest, 1'b0, hb, "R7 payload word");
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_out(1'b0, 1'b0, 1'b0, "R9 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_out(1'b0, 1'b0, 1'b0, "R9 after reset");
        held = 1'b0;
    endtask

    initial begin
        int lens [3] = '{4, 7, 12};
        for (int li = 0; li < 3; li++) begin
            int L;
            L = lens[li];
            meta_len = LEN_W'(L);   // R10: several lengths
            do_reset();

            // R1: three confirmations not enough, fourth locks
            for (int k = 0; k < 3; k++) send_frame(L, 1, 0, 1, 0, 1'b0, 1'b0, "R1 before lock");
            send_frame(L, 1, 0, 1, 0, 1'b1, 1'b1, "R1 lock on fourth");
            // R6/R8/R10: locked frames, one with idle gaps
            send_frame(L, 1, 0, 1, 1, 1'b1, 1'b1, "R6 R8 locked with gap");
            send_frame(L, 1, 0, 1, 0, 1'b1, 1'b1, "R6 R10 locked");
            // R5: two misses, match, two misses keep lock
            send_frame(L, 1, 0, 0, 0, 1'b1, 1'b1, "R5 miss one");
            send_frame(L, 1, 0, 0, 0, 1'b1, 1'b1, "R5 miss two");
            send_frame(L, 1, 0, 1, 0, 1'b1, 1'b1, "R5 match clears");
            send_frame(L, 1, 0, 0, 0, 1'b1, 1'b1, "R5 miss one again");
            send_frame(L, 1, 0, 0, 1, 1'b1, 1'b1, "R5 miss two again");
            // R4: third consecutive miss drops lock
            send_frame(L, 1, 0, 0, 0, 1'b1, 1'b0, "R4 third miss");
            // R3: new candidate, two more, then a missing sync
            for (int k = 0; k < 3; k++) send_frame(L, 1, 0, 1, 0, 1'b0, 1'b0, "R4 R3 relock search");
            send_frame(L, 0, 0, 1, 0, 1'b0, 1'b0, "R3 missing sync");
            for (int k = 0; k < 3; k++) send_frame(L, 1, 0, 1, 0, 1'b0, 1'b0, "R3 count restarted");
            send_frame(L, 1, 0, 1, 1, 1'b1, 1'b1, "R3 relock on fourth");
            send_frame(L, 1, 0, 1, 0, 1'b1, 1'b1, "R6 R10 after relock");

            // R2: pattern with data header never becomes a candidate
            do_reset();
            for (int k = 0; k < 5; k++) send_frame(L, 0, 1, 1, 0, 1'b0, 1'b0, "R2 fake sync ignored");
            for (int k = 0; k < 3; k++) send_frame(L, 1, 0, 1, 0, 1'b0, 1'b0, "R2 real sync search");
            send_frame(L, 1, 0, 1, 0, 1'b1, 1'b1, "R2 R1 lock");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still active, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule